// File: doc/BRIEF.md
# External Static Memory Access Sequencer with Wait Stretching

This block drives the read strobe, write strobe, address, byte enables and data-bus enable for one chip select of an external asynchronous static memory bus. A client presents a request (address, write data, byte enables, direction). The block accepts it when it is idle. It then steps the access through a setup phase, a strobe pulse phase and a hold phase, each with its own programmed cycle count for reads and for writes. After a read it waits a programmed number of data-float cycles, so the memory can release the bus, before it accepts anything else.

An active-low wait input lets the external device stretch an access. The input first passes through a two-flop synchronizer and is looked at only while a strobe is in its pulse phase. A two-bit mode field selects how the wait input acts. In the ignored mode nothing happens. In the frozen mode the whole sequencer stops while wait is asserted and resumes from the same point. In the ready mode the pulse cannot end until its count has run out and wait has been released. Any enabled wait mode needs a hold count of at least one. A configuration that breaks this rule is flagged, and no request is accepted while it stands.

The controller is one state machine with five states. IDLE goes to SETUP on acceptance, or straight to PULSE when the setup count is zero. SETUP goes to PULSE when its count expires. PULSE goes to HOLD when the pulse ends, or straight to the end-of-access step when the hold count is zero. HOLD goes to the end-of-access step when its count expires. The end-of-access step leads to FLOAT for a read with a non-zero float count, and back to IDLE otherwise. FLOAT goes to IDLE when its count expires. In PULSE there are two extra self-transitions: the frozen stall, and the ready stretch at an expired count.

Top module: `xmem_access_seq`

## Requirements
- R1: While reset is asserted and right after it is released, both strobes are high (inactive) and the data-bus enable is low. The accept signal is high whenever the configuration is legal.
- R2: `req_ready` is high only in IDLE with no configuration error. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The captured address, byte enables and write data stay on the memory outputs, unchanged, from the first setup cycle through the last hold cycle.
- R3: A read drives `mem_rd_n` low for exactly the read pulse count of cycles. Before that come read-setup-count cycles, and after it come read-hold-count cycles with the strobe high. A setup or hold count of 0 skips that phase. A pulse count of 0 acts as 1. The two strobes are never low together.
- R4: A write drives `mem_wr_n` low with the same phase rules, using the write counts. `mem_doe` is high from the first write setup cycle through the last write hold cycle and is never high during a read or an idle cycle.
- R5: After a read, the block spends exactly the float count of cycles with both strobes high, `mem_doe` low and `req_ready` low, before it returns to IDLE. A float count of 0 adds no cycles, and writes add none.
- R6: `cfg_wait_mode` encodes 0 as ignore, 1 as ignore (reserved), 2 as frozen and 3 as ready. In the ignore encodings, `mem_wait_n` has no effect on any output.
- R7: `mem_wait_n` passes through a two-flop synchronizer. A low level sampled at clock edge k can stall the pulse decision at edge k+2 at the earliest. A wait that arrives only in the last two pulse cycles does not lengthen the pulse.
- R8: The synchronized wait has an effect only in the pulse phase. A wait seen during setup, hold, float or idle changes no output.
- R9: In frozen mode (2), each pulse-phase cycle with the synchronized wait asserted adds one cycle to the pulse. The phase counter and all outputs keep their values, and the access then goes on from where it stopped.
- R10: In ready mode (3), the pulse ends only at the first edge where the pulse count has run out and the synchronized wait is deasserted. A wait that goes away before the count runs out does not lengthen the pulse.
- R11: `cfg_error` is high exactly when the wait mode is 2 or 3 and the read hold count or the write hold count is zero. While it is high, `req_ready` stays low and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client has an access ready |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_pulse | input | CNT_W | Read strobe pulse cycles (0 acts as 1) |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_pulse | input | CNT_W | Write strobe pulse cycles (0 acts as 1) |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| cfg_float | input | CNT_W | Data-float cycles after a read |
| cfg_wait_mode | input | 2 | 0/1 ignore, 2 frozen, 3 ready |
| cfg_error | output | 1 | Wait enabled with a zero hold count |
| mem_wait_n | input | 1 | Asynchronous active-low wait from the device |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_be | output | BE_W | Byte enables to the memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W | Write data to the memory |
| mem_doe | output | 1 | Data-bus output enable |

## Verification
The properties assume that the timing and mode fields stay constant while an access is in flight, and that `req_valid` is only withdrawn after acceptance. The bench changes configuration only once it sees `req_ready` high again, and it drops the request on the cycle after acceptance. The properties also assume the wait input is a level that may change on any cycle, because the synchronizer absorbs it. The bench therefore drives wait both in fixed windows placed against the setup, pulse and hold phases and as a pseudo-random level every cycle, while a behavioural model predicts every output on every clock.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_FLOAT = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        WM_OFF    = 2'd0,
        WM_RSVD   = 2'd1,
        WM_FROZEN = 2'd2,
        WM_READY  = 2'd3
    } wait_mode_t;

endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_active
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_active = ~chain[STAGES-1];
endmodule

// File: rtl/xmem_phase_cnt.sv
module xmem_phase_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/xmem_cfg_check.sv
module xmem_cfg_check #(
    parameter int CNT_W = 6
) (
    input  logic [1:0]       wait_mode,
    input  logic [CNT_W-1:0] rd_hold,
    input  logic [CNT_W-1:0] wr_hold,
    output logic             is_frozen,
    output logic             is_ready,
    output logic             bad_cfg
);
    import xmem_seq_pkg::*;

    logic enabled;

    always_comb begin
        is_frozen = (wait_mode == WM_FROZEN);
        is_ready  = (wait_mode == WM_READY);
        enabled   = is_frozen | is_ready;
        bad_cfg   = enabled && ((rd_hold == '0) || (wr_hold == '0));
    end
endmodule

// File: rtl/xmem_access_seq.sv
module xmem_access_seq #(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [CNT_W-1:0]      cfg_rd_setup,
    input  logic [CNT_W-1:0]      cfg_rd_pulse,
    input  logic [CNT_W-1:0]      cfg_rd_hold,
    input  logic [CNT_W-1:0]      cfg_wr_setup,
    input  logic [CNT_W-1:0]      cfg_wr_pulse,
    input  logic [CNT_W-1:0]      cfg_wr_hold,
    input  logic [CNT_W-1:0]      cfg_float,
    input  logic [1:0]            cfg_wait_mode,
    output logic                  cfg_error,
    input  logic                  mem_wait_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n,
    output logic [DATA_W-1:0]     mem_dout,
    output logic                  mem_doe
);
    import xmem_seq_pkg::*;

    localparam int BE_W = DATA_W / 8;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t        state, nxt_state;
    logic              wait_sync;
    logic              mode_frozen, mode_ready;
    logic              cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0]  cnt_val, cnt;
    logic              accept;

    logic              is_wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;

    logic [CNT_W-1:0]  cur_pulse, cur_hold;
    logic [CNT_W-1:0]  new_setup, new_pulse;
    seq_state_t        end_state;
    logic [CNT_W-1:0]  end_val;
    logic              frz_stall, rdy_stall;

    xmem_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_n    (mem_wait_n),
        .sync_active(wait_sync)
    );

    xmem_cfg_check #(.CNT_W(CNT_W)) u_cfg (
        .wait_mode(cfg_wait_mode),
        .rd_hold  (cfg_rd_hold),
        .wr_hold  (cfg_wr_hold),
        .is_frozen(mode_frozen),
        .is_ready (mode_ready),
        .bad_cfg  (cfg_error)
    );

    xmem_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .cnt     (cnt),
        .zero    (cnt_zero)
    );

    assign req_ready = (state == ST_IDLE) && !cfg_error;
    assign accept    = req_valid && req_ready;

    // Timing selection for the access in flight and for a new request
    always_comb begin
        cur_pulse = is_wr_q ? cfg_wr_pulse : cfg_rd_pulse;
        cur_hold  = is_wr_q ? cfg_wr_hold  : cfg_rd_hold;
        if (cur_pulse == '0) cur_pulse = ONE;
        new_setup = req_write ? cfg_wr_setup : cfg_rd_setup;
        new_pulse = req_write ? cfg_wr_pulse : cfg_rd_pulse;
        if (new_pulse == '0) new_pulse = ONE;
        if (!is_wr_q && cfg_float != '0) begin
            end_state = ST_FLOAT;
            end_val   = cfg_float - ONE;
        end else begin
            end_state = ST_IDLE;
            end_val   = '0;
        end
        frz_stall = mode_frozen && wait_sync;
        rdy_stall = mode_ready && wait_sync && cnt_zero;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            is_wr_q <= req_write;
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    // Transitions and counter control
    always_comb begin
        nxt_state = state;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    cnt_load = 1'b1;
                    if (new_setup != '0) begin
                        nxt_state = ST_SETUP;
                        cnt_val   = new_setup - ONE;
                    end else begin
                        nxt_state = ST_PULSE;
                        cnt_val   = new_pulse - ONE;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    nxt_state = ST_PULSE;
                    cnt_load  = 1'b1;
                    cnt_val   = cur_pulse - ONE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_PULSE: begin
                if (frz_stall) begin
                    nxt_state = ST_PULSE;
                end else if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (!rdy_stall) begin
                    cnt_load = 1'b1;
                    if (cur_hold != '0) begin
                        nxt_state = ST_HOLD;
                        cnt_val   = cur_hold - ONE;
                    end else begin
                        nxt_state = end_state;
                        cnt_val   = end_val;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    nxt_state = end_state;
                    cnt_load  = 1'b1;
                    cnt_val   = end_val;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_FLOAT: begin
                if (cnt_zero) nxt_state = ST_IDLE;
                else          cnt_dec   = 1'b1;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd_n = 1'b1;
        mem_wr_n = 1'b1;
        mem_doe  = 1'b0;
        mem_addr = addr_q;
        mem_be   = be_q;
        mem_dout = wdata_q;
        unique case (state)
            ST_SETUP, ST_HOLD: mem_doe = is_wr_q;
            ST_PULSE: begin
                mem_doe  = is_wr_q;
                mem_wr_n = !is_wr_q;
                mem_rd_n = is_wr_q;
            end
            ST_IDLE, ST_FLOAT: mem_doe = 1'b0;
            default: mem_doe = 1'b0;
        endcase
    end

endmodule

// File: rtl/xmem_access_seq_chk.sv
module xmem_access_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input xmem_seq_pkg::seq_state_t state,
    input logic [CNT_W-1:0]         cnt,
    input logic                     cnt_zero,
    input logic                     wait_sync,
    input logic [1:0]               cfg_wait_mode,
    input logic                     cfg_error,
    input logic                     req_ready,
    input logic [ADDR_W-1:0]        mem_addr,
    input logic                     mem_rd_n,
    input logic                     mem_wr_n,
    input logic                     mem_doe
);
    import xmem_seq_pkg::*;

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    assert_doe_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> mem_rd_n);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_rd_n && mem_wr_n && !mem_doe));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr));

    assert_float_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAT) |-> (mem_rd_n && mem_wr_n && !mem_doe && !req_ready));

    assert_wait_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cnt_zero && !cfg_wait_mode[1]) |=> (state != ST_PULSE));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cfg_wait_mode == 2'd2 && wait_sync)
        |=> (state == ST_PULSE && $stable(cnt) && $stable(mem_addr)));

    assert_ready_stretch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cnt_zero && cfg_wait_mode == 2'd3 && wait_sync)
        |=> (state == ST_PULSE));

    assert_reject_bad_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !req_ready);

endmodule

bind xmem_access_seq xmem_access_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .cnt          (cnt),
    .cnt_zero     (cnt_zero),
    .wait_sync    (wait_sync),
    .cfg_wait_mode(cfg_wait_mode),
    .cfg_error    (cfg_error),
    .req_ready    (req_ready),
    .mem_addr     (mem_addr),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .mem_doe      (mem_doe)
);

// File: tb/sim_xmem_access_seq.sv
`timescale 1ns/1ps
module sim_xmem_access_seq;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [CW-1:0] rS = 6'd1, rP = 6'd2, rH = 6'd1, wS = 6'd1, wP = 6'd2, wH = 6'd1, flt = 6'd0;
    logic [1:0]    wmode = 2'd0;
    logic          wait_n = 1'b1;

    logic          req_ready, cfg_error, mem_rd_n, mem_wr_n, mem_doe;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be;
    logic [DW-1:0] mem_dout;

    xmem_access_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .cfg_rd_setup(rS), .cfg_rd_pulse(rP), .cfg_rd_hold(rH),
        .cfg_wr_setup(wS), .cfg_wr_pulse(wP), .cfg_wr_hold(wH),
        .cfg_float(flt), .cfg_wait_mode(wmode), .cfg_error(cfg_error),
        .mem_wait_n(wait_n), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_dout(mem_dout), .mem_doe(mem_doe)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference: phase 0 idle, 1 setup, 2 pulse, 3 hold, 4 float
    int            m_ph = 0, m_left = 0;
    logic          m_wr = 0, m_s1 = 1, m_s2 = 1, m_acc = 0;
    logic [AW-1:0] m_addr = '0;
    logic [BW-1:0] m_be = '0;
    logic [DW-1:0] m_data = '0;
    int c_rd, c_wr, c_doe, c_busy;
    logic [31:0] lfsr = 32'h1badf00d;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit bad_cfg();
        return (wmode[1] && (rH == 0 || wH == 0));
    endfunction

    function automatic int pulse_of(input logic wr);
        int p = wr ? int'(wP) : int'(rP);
        return (p == 0) ? 1 : p;
    endfunction

    task automatic after_access();
        if (!m_wr && flt != 0) begin m_ph = 4; m_left = int'(flt); end
        else m_ph = 0;
    endtask

    task automatic after_pulse();
        int h = m_wr ? int'(wH) : int'(rH);
        if (h != 0) begin m_ph = 3; m_left = h; end
        else after_access();
    endtask

    task automatic model_step();
        logic waitv = !m_s2;
        int s;
        m_acc = 0;
        case (m_ph)
            0: if (req_valid && !bad_cfg()) begin
                m_acc = 1; m_wr = req_write; m_addr = req_addr; m_be = req_be; m_data = req_wdata;
                s = req_write ? int'(wS) : int'(rS);
                if (s != 0) begin m_ph = 1; m_left = s; end
                else begin m_ph = 2; m_left = pulse_of(m_wr); end
            end
            1: if (m_left > 1) m_left--; else begin m_ph = 2; m_left = pulse_of(m_wr); end
            2: begin
                if (wmode == 2'd2 && waitv) begin end
                else if (m_left > 1) m_left--;
                else if (wmode == 2'd3 && waitv) begin end
                else after_pulse();
            end
            3: if (m_left > 1) m_left--; else after_access();
            4: if (m_left > 1) m_left--; else m_ph = 0;
            default: m_ph = 0;
        endcase
        m_s2 = m_s1;
        m_s1 = wait_n;
    endtask

    task automatic compare();
        logic busy = (m_ph >= 1 && m_ph <= 3);
        check("R3 rd_n", mem_rd_n, !(m_ph == 2 && !m_wr));
        check("R4 wr_n", mem_wr_n, !(m_ph == 2 && m_wr));
        check("R4 doe", mem_doe, busy && m_wr);
        check("R2 ready", req_ready, (m_ph == 0) && !bad_cfg());
        check("R11 error", cfg_error, bad_cfg());
        if (busy) begin
            check("R2 addr", mem_addr, m_addr);
            check("R2 be", mem_be, m_be);
            if (m_wr) check("R4 dout", mem_dout, m_data);
        end
        if (!mem_rd_n) c_rd++;
        if (!mem_wr_n) c_wr++;
        if (mem_doe) c_doe++;
        if (!req_ready) c_busy++;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    // one access; wait_n low for loop index k in [wfrom, wto), or random when rnd
    task automatic access(input logic wr, input logic [AW-1:0] a, input int wfrom,
                          input int wto, input bit rnd);
        int guard = 0;
        c_rd = 0; c_wr = 0; c_doe = 0; c_busy = 0;
        req_write = wr; req_addr = a; req_be = a[BW-1:0] | 2'b01; req_wdata = a[DW-1:0] ^ 16'h5a5a;
        req_valid = 1'b1;
        do begin tick(); guard++; end while (!m_acc && guard < 50);
        req_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (req_ready) break;
            if (rnd) begin next_rand(); wait_n = lfsr[3] | lfsr[7]; end
            else wait_n = !(k >= wfrom && k < wto);
            tick();
        end
        wait_n = 1'b1;
        if (!req_ready) check("R2 access completes", 0, 1);
    endtask

    task automatic set_cfg(input int a, b, c, d, e, f, g, input logic [1:0] m);
        rS = CW'(a); rP = CW'(b); rH = CW'(c); wS = CW'(d); wP = CW'(e); wH = CW'(f);
        flt = CW'(g); wmode = m;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_n in reset", mem_rd_n, 1);
        check("R1 wr_n in reset", mem_wr_n, 1);
        check("R1 doe in reset", mem_doe, 0);
        rst_n = 1'b1;
        tick();
        check("R1 ready after reset", req_ready, 1);

        // R3 R5: read S1 P2 H1 float 5 -> busy 1+2+1+5
        set_cfg(1, 2, 1, 1, 3, 1, 5, 2'd0);
        access(0, 24'h000100, 0, 0, 0);
        check("R3 read pulse length", c_rd, 2);
        check("R5 read busy incl float", c_busy, 9);
        check("R4 no doe on read", c_doe, 0);
        // R4 R5: write directly after, no float after write
        access(1, 24'h000202, 0, 0, 0);
        check("R4 write pulse length", c_wr, 3);
        check("R4 doe window", c_doe, 5);
        check("R5 write adds no float", c_busy, 5);
        // R3: zero setup/hold/pulse
        set_cfg(0, 0, 0, 0, 0, 0, 0, 2'd0);
        access(0, 24'h000333, 0, 0, 0);
        check("R3 zero counts rd", c_rd, 1);
        check("R3 zero counts busy", c_busy, 1);

        // R6 R9 R10: S1 P3 H1, wait low for k in [0,4)
        set_cfg(1, 3, 1, 1, 3, 1, 0, 2'd0);
        access(0, 24'h000400, 0, 4, 0);
        check("R6 mode0 ignores wait", c_rd, 3);
        wmode = 2'd1;
        access(0, 24'h000401, 0, 4, 0);
        check("R6 mode1 ignores wait", c_rd, 3);
        wmode = 2'd2;
        access(0, 24'h000402, 0, 4, 0);
        check("R9 frozen stretch", c_rd, 7);
        wmode = 2'd3;
        access(0, 24'h000403, 0, 4, 0);
        check("R10 ready stretch", c_rd, 6);
        access(1, 24'h000404, 0, 4, 0);
        check("R10 ready stretch write", c_wr, 6);

        // R7: late wait does not stretch, early one does
        wmode = 2'd2;
        access(0, 24'h000500, 3, 4, 0);
        check("R7 late wait no stretch", c_rd, 3);
        access(0, 24'h000501, 1, 2, 0);
        check("R7 sync latency stretch", c_rd, 4);
        // R10: wait released before count expiry does not stretch
        wmode = 2'd3;
        access(0, 24'h000502, 0, 1, 0);
        check("R10 early wait no stretch", c_rd, 3);

        // R8: wait only during long setup
        set_cfg(6, 2, 1, 6, 2, 1, 0, 2'd2);
        access(0, 24'h000600, 0, 3, 0);
        check("R8 setup wait ignored", c_rd, 2);
        check("R8 setup wait busy", c_busy, 9);

        // R11: wait enabled with zero hold
        set_cfg(1, 2, 1, 1, 2, 0, 0, 2'd3);
        req_valid = 1'b1;
        c_wr = 0; c_rd = 0;
        for (int i = 0; i < 5; i++) tick();
        req_valid = 1'b0;
        check("R11 error flagged", cfg_error, 1);
        check("R11 no access started", c_rd + c_wr, 0);

        // pseudo-random configurations and wait, model compared every clock
        for (int n = 0; n < 60; n++) begin
            next_rand();
            set_cfg(lfsr[2:0], lfsr[5:3], 1 + lfsr[7:6], lfsr[10:8], lfsr[13:11],
                    1 + lfsr[15:14], lfsr[18:16], lfsr[20:19]);
            access(lfsr[21], AW'(lfsr[31:8]), 0, 0, 1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule